// File: doc/BRIEF.md
# Serial Debug Bus Register Slave

This block sits on a five-wire serial debug bus and exposes a handful of small registers of one arbiter slice. The bus master raises an address strobe and clocks in a 16-bit address, most significant bit first, one bit per rising edge of the shift clock. A slave responds only when the top address bit is set and the next three bits match its slot number. Once the strobe drops, each further shift-clock pulse moves one bit through the addressed register. The bit that leaves the register appears on serial out, and the bit on serial in enters it.

The slave has a read-only signature, a 4-bit mode word, a 2-bit board version, a one-bit version shadow and a configuration shift chain. The mode word carries the arbiter number and the hybrid-select format. Addressing a hybrid number in address bits 11:8 drives five active-low select lines, either one-hot or as a binary code. All bus inputs are oversampled by the system clock. Serial out is registered and changes only on falling shift-clock edges. The master can therefore sample it on the rising edge.

Top module: `dbs_slave`

## Requirements
- R1: While the strobe is high, each rising shift-clock edge shifts serial in into a 16-bit address, MSB first. After the strobe drops, the slave is selected only if address bit 15 is 1 and bits 14:12 equal `slot_i`.
- R2: Offset 0x000 is a read-only signature that shifts out as 0x5041, MSB first. Shifting data into it does not change what the next read returns.
- R3: Offset 0x002 is a 4-bit mode register, written MSB first. Its previous contents come out on serial out during the write. Bits 3:1 appear on `arb_num_o`. Bit 0 selects decoded (1) or encoded (0) hybrid format. Reset value is 0.
- R4: Let h be address bits 11:8. When the slave is selected, the strobe is low and h is nonzero, `hyb_sel_no` is driven as follows. In decoded mode, bit h-1 is low for h from 1 to 5 and all lines are high otherwise. In encoded mode the lines are the inverse of {h,0}; for h=3 this gives 0x1B decoded and 0x19 encoded. In every other case, including whenever the strobe is high, all five lines are high.
- R5: Offset 0x003 reads a 2-bit board version, MSB first, equal to 2 XOR {0, shadow}. The one-bit shadow at offset 0x400 resets to 1, so the version reads 3 after reset and 2 once the shadow is written with 0.
- R6: Offset 0x004 is a CFG_W-bit (default 12) shift chain, MSB first, with its contents on `cfg_o`. A bit shifted in comes out on serial out unchanged after CFG_W more shifts.
- R7: Serial out changes only after a falling shift-clock edge or a bus reset. It is high during the address phase, and it stays high after the strobe drops until the first falling edge.
- R8: Shifting while the slave is not selected (wrong slot, bit 15 clear, or an unmapped offset) leaves the mode, shadow and configuration contents unchanged and holds serial out high.
- R9: Holding `dbg_rst_ni` low clears the address, the mode register and the chain, sets the shadow to 1, and drives serial out high.
- R10: `rst_ni` low resets the same state asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_i | input | 3 | Slot number this slave answers to |
| dbg_strobe_i | input | 1 | Address strobe, high during the address phase |
| dbg_sck_i | input | 1 | Bus shift clock, idles high |
| dbg_sdi_i | input | 1 | Serial data from the master |
| dbg_rst_ni | input | 1 | Active-low bus reset |
| dbg_sdo_o | output | 1 | Serial data to the master, high when idle |
| hyb_sel_no | output | 5 | Active-low hybrid select lines |
| arb_num_o | output | 3 | Arbiter number held in the mode register |
| cfg_o | output | CFG_W | Configuration chain contents |

## Verification
The bench checks several cases that a faulty slave would get visibly wrong:
- The first data bit: if serial out updated on rising edges, or were never held high after the address phase, the signature would read shifted by one bit.
- Over-length writes to the configuration chain, which start with random check bits: a chain of the wrong length, or a tap off by one, returns the wrong check bits.
- Random hybrid numbers in both modes, including out-of-range values in decoded mode and a strobe raised mid-select: a decoder that ignores the mode bit or the strobe drives the wrong lines.
- Accesses to the wrong slot, with bit 15 clear, or to an unmapped offset, followed by bus and asynchronous resets: a slave that decodes too loosely corrupts its registers or drives serial out low.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int ADDR_W  = 16;
  localparam int SLOT_W  = 3;
  localparam int OFF_W   = 12;
  localparam int HIDX_W  = 4;
  localparam int MODE_W  = 4;
  localparam int SIG_W   = 16;
  localparam int VER_W   = 2;
  localparam logic [SIG_W-1:0] SIG_VALUE = 16'h5041;

  localparam logic [OFF_W-1:0] OFF_SIG    = 12'h000;
  localparam logic [OFF_W-1:0] OFF_MODE   = 12'h002;
  localparam logic [OFF_W-1:0] OFF_VER    = 12'h003;
  localparam logic [OFF_W-1:0] OFF_CFG    = 12'h004;
  localparam logic [OFF_W-1:0] OFF_SHADOW = 12'h400;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SIG,
    SEL_MODE,
    SEL_VER,
    SEL_CFG,
    SEL_SHADOW
  } reg_sel_e;
endpackage

// File: rtl/dbs_sync.sv
module dbs_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dbs_addr.sv
module dbs_addr
  import dbs_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_rst_n_i,
  input  logic                 strobe_i,
  input  logic                 sck_rise_i,
  input  logic                 sdi_i,
  input  logic [SLOT_W-1:0]    slot_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 hit_o,
  output reg_sel_e             sel_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               addr_q <= '0;
    else if (!bus_rst_n_i)     addr_q <= '0;
    else if (strobe_i && sck_rise_i) addr_q <= {addr_q[ADDR_W-2:0], sdi_i};
  end

  // slot match uses the bits just below the enable bit
  assign hit_o = !strobe_i && addr_q[ADDR_W-1] &&
                 (addr_q[ADDR_W-2 -: SLOT_W] == slot_i);

  always_comb begin
    sel_o = SEL_NONE;
    if (hit_o) begin
      case (addr_q[OFF_W-1:0])
        OFF_SIG:    sel_o = SEL_SIG;
        OFF_MODE:   sel_o = SEL_MODE;
        OFF_VER:    sel_o = SEL_VER;
        OFF_CFG:    sel_o = SEL_CFG;
        OFF_SHADOW: sel_o = SEL_SHADOW;
        default:    sel_o = SEL_NONE;
      endcase
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/dbs_regs.sv
module dbs_regs
  import dbs_pkg::*;
#(
  parameter int               CFG_W     = 12,
  parameter logic [VER_W-1:0] BOARD_VER = 2'd2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_rst_n_i,
  input  reg_sel_e           sel_i,
  input  logic               sck_rise_i,
  input  logic               sck_fall_i,
  input  logic               sdi_i,
  output logic [MODE_W-1:0]  mode_o,
  output logic [CFG_W-1:0]   cfg_o,
  output logic               sdo_o
);
  logic [SIG_W-1:0]  sig_sh_q;
  logic [VER_W-1:0]  ver_sh_q;
  logic [VER_W-1:0]  ver_val;
  logic [MODE_W-1:0] mode_q;
  logic [CFG_W-1:0]  cfg_q;
  logic              shadow_q;
  logic              sdo_q;
  logic              sdo_nxt;

  assign ver_val = BOARD_VER ^ {{(VER_W-1){1'b0}}, shadow_q};

  // read-only chains reload whenever they are not the target
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_sh_q <= SIG_VALUE;
      ver_sh_q <= BOARD_VER ^ {{(VER_W-1){1'b0}}, 1'b1};
    end else begin
      if (sel_i != SEL_SIG)      sig_sh_q <= SIG_VALUE;
      else if (sck_rise_i)       sig_sh_q <= {sig_sh_q[SIG_W-2:0], sdi_i};
      if (sel_i != SEL_VER)      ver_sh_q <= ver_val;
      else if (sck_rise_i)       ver_sh_q <= {ver_sh_q[VER_W-2:0], sdi_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      cfg_q    <= '0;
      shadow_q <= 1'b1;
    end else if (!bus_rst_n_i) begin
      mode_q   <= '0;
      cfg_q    <= '0;
      shadow_q <= 1'b1;
    end else if (sck_rise_i) begin
      case (sel_i)
        SEL_MODE:   mode_q   <= {mode_q[MODE_W-2:0], sdi_i};
        SEL_CFG:    cfg_q    <= {cfg_q[CFG_W-2:0], sdi_i};
        SEL_SHADOW: shadow_q <= sdi_i;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (sel_i)
      SEL_SIG:    sdo_nxt = sig_sh_q[SIG_W-1];
      SEL_MODE:   sdo_nxt = mode_q[MODE_W-1];
      SEL_VER:    sdo_nxt = ver_sh_q[VER_W-1];
      SEL_CFG:    sdo_nxt = cfg_q[CFG_W-1];
      SEL_SHADOW: sdo_nxt = shadow_q;
      default:    sdo_nxt = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sdo_q <= 1'b1;
    else if (!bus_rst_n_i) sdo_q <= 1'b1;
    else if (sck_fall_i)  sdo_q <= sdo_nxt;
  end

  assign mode_o = mode_q;
  assign cfg_o  = cfg_q;
  assign sdo_o  = sdo_q;
endmodule

// File: rtl/dbs_hyb.sv
module dbs_hyb
  import dbs_pkg::*;
#(
  parameter int HYB_W = 5
) (
  input  logic              hit_i,
  input  logic [HIDX_W-1:0] hidx_i,
  input  logic              decoded_i,
  output logic [HYB_W-1:0]  hyb_sel_no
);
  logic [HYB_W-1:0] dec_n;
  logic [HYB_W-1:0] enc_n;
  logic             active;

  assign active = hit_i && (hidx_i != '0);

  generate
    for (genvar i = 0; i < HYB_W; i++) begin : g_dec
      assign dec_n[i] = !(active && (hidx_i == HIDX_W'(i + 1)));
    end
  endgenerate

  assign enc_n = active ? ~HYB_W'({hidx_i, 1'b0}) : '1;

  assign hyb_sel_no = decoded_i ? dec_n : enc_n;
endmodule

// File: rtl/dbs_slave.sv
module dbs_slave
  import dbs_pkg::*;
#(
  parameter int               CFG_W       = 12,
  parameter int               HYB_W       = 5,
  parameter int               SYNC_STAGES = 2,
  parameter logic [VER_W-1:0] BOARD_VER   = 2'd2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic               dbg_strobe_i,
  input  logic               dbg_sck_i,
  input  logic               dbg_sdi_i,
  input  logic               dbg_rst_ni,
  output logic               dbg_sdo_o,
  output logic [HYB_W-1:0]   hyb_sel_no,
  output logic [SLOT_W-1:0]  arb_num_o,
  output logic [CFG_W-1:0]   cfg_o
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0]  sync_q;
  logic              bus_rst_n_s, strobe_s, sck_s, sdi_s;
  logic              sck_d;
  logic              sck_rise, sck_fall;
  logic [ADDR_W-1:0] addr_q;
  logic              hit;
  reg_sel_e          sel;
  logic [MODE_W-1:0] mode_q;

  // bus reset held asserted and shift clock idle high out of reset
  dbs_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dbg_rst_ni, dbg_strobe_i, dbg_sck_i, dbg_sdi_i}),
    .q_o   (sync_q)
  );
  assign {bus_rst_n_s, strobe_s, sck_s, sdi_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d <= 1'b1;
    else         sck_d <= sck_s;
  end
  assign sck_rise =  sck_s && !sck_d;
  assign sck_fall = !sck_s &&  sck_d;

  dbs_addr u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_rst_n_i(bus_rst_n_s),
    .strobe_i   (strobe_s),
    .sck_rise_i (sck_rise),
    .sdi_i      (sdi_s),
    .slot_i     (slot_i),
    .addr_o     (addr_q),
    .hit_o      (hit),
    .sel_o      (sel)
  );

  dbs_regs #(.CFG_W(CFG_W), .BOARD_VER(BOARD_VER)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_rst_n_i(bus_rst_n_s),
    .sel_i      (sel),
    .sck_rise_i (sck_rise),
    .sck_fall_i (sck_fall),
    .sdi_i      (sdi_s),
    .mode_o     (mode_q),
    .cfg_o      (cfg_o),
    .sdo_o      (dbg_sdo_o)
  );

  dbs_hyb #(.HYB_W(HYB_W)) u_hyb (
    .hit_i     (hit),
    .hidx_i    (addr_q[OFF_W-1 -: HIDX_W]),
    .decoded_i (mode_q[0]),
    .hyb_sel_no(hyb_sel_no)
  );

  assign arb_num_o = mode_q[MODE_W-1:1];
endmodule

// File: rtl/dbs_slave_chk.sv
module dbs_slave_chk
  import dbs_pkg::*;
#(
  parameter int CFG_W = 12,
  parameter int HYB_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_rst_n_s,
  input logic              strobe_s,
  input logic              sdi_s,
  input logic              sck_rise,
  input logic              sck_fall,
  input reg_sel_e          sel,
  input logic [MODE_W-1:0] mode_q,
  input logic              dbg_sdo_o,
  input logic [HYB_W-1:0]  hyb_sel_no,
  input logic [SLOT_W-1:0] arb_num_o,
  input logic [CFG_W-1:0]  cfg_o
);
  AST_SDO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dbg_sdo_o) |-> $past(sck_fall || !bus_rst_n_s)); // R7

  AST_HYB_STROBE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_s |-> (hyb_sel_no == '1)); // R4

  AST_HYB_DEC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q[0] |-> ($countones(~hyb_sel_no) <= 1)); // R4

  AST_CFG_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_CFG && sck_rise && bus_rst_n_s) |=> (cfg_o[0] == $past(sdi_s))); // R6

  AST_UNSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_NONE && bus_rst_n_s) |=> ($stable(cfg_o) && $stable(arb_num_o))); // R8

  AST_BUS_RST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rst_n_s |=> (cfg_o == '0 && arb_num_o == '0 && dbg_sdo_o)); // R9
endmodule

bind dbs_slave dbs_slave_chk #(.CFG_W(CFG_W), .HYB_W(HYB_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_rst_n_s(bus_rst_n_s),
  .strobe_s   (strobe_s),
  .sdi_s      (sdi_s),
  .sck_rise   (sck_rise),
  .sck_fall   (sck_fall),
  .sel        (sel),
  .mode_q     (mode_q),
  .dbg_sdo_o  (dbg_sdo_o),
  .hyb_sel_no (hyb_sel_no),
  .arb_num_o  (arb_num_o),
  .cfg_o      (cfg_o)
);

// File: tb/dbs_slave_tb.sv
module dbs_slave_tb;
  localparam int CFG_W = 12;
  localparam int HYB_W = 5;

  logic clk = 1'b0;
  logic rst_ni, dbg_strobe, dbg_sck, dbg_sdi, dbg_rst_n;
  logic [2:0] slot;
  logic dbg_sdo;
  logic [HYB_W-1:0] hyb_sel_n;
  logic [2:0] arb_num;
  logic [CFG_W-1:0] cfg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbs_slave #(.CFG_W(CFG_W), .HYB_W(HYB_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .slot_i(slot),
    .dbg_strobe_i(dbg_strobe), .dbg_sck_i(dbg_sck), .dbg_sdi_i(dbg_sdi),
    .dbg_rst_ni(dbg_rst_n), .dbg_sdo_o(dbg_sdo), .hyb_sel_no(hyb_sel_n),
    .arb_num_o(arb_num), .cfg_o(cfg)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer_bit(input logic b, output logic so);
    dbg_sdi = b;
    dbg_sck = 1'b0;
    wait_n(6);
    so = dbg_sdo;
    dbg_sck = 1'b1;
    wait_n(6);
  endtask

  task automatic shift_bits(input int n, input logic [31:0] vin, output logic [31:0] vout);
    logic so;
    vout = '0;
    for (int i = n - 1; i >= 0; i--) begin
      xfer_bit(vin[i], so);
      vout = {vout[30:0], so};
    end
  endtask

  task automatic addr_shift(input logic [15:0] a);
    logic [31:0] dummy;
    dbg_strobe = 1'b1;
    wait_n(6);
    shift_bits(16, {16'h0, a}, dummy);
    dbg_strobe = 1'b0;
    wait_n(6);
  endtask

  function automatic logic [15:0] sel_addr(input logic [2:0] s, input logic [11:0] off);
    return 16'h8000 | (16'(s) << 12) | 16'(off);
  endfunction

  function automatic logic [4:0] exp_hyb(input logic [3:0] h, input bit dec);
    if (h == 0) return 5'h1F;
    if (dec) return (h <= 5) ? ~(5'd1 << (h - 1)) : 5'h1F;
    return ~{h, 1'b0};
  endfunction

  task automatic write_mode(input logic [3:0] m);
    logic [31:0] r;
    addr_shift(sel_addr(slot, 12'h002));
    shift_bits(4, {28'h0, m}, r);
  endtask

  initial begin
    logic [31:0] r, exp_v;
    logic [CFG_W-1:0] prev_cfg;
    void'($urandom(32'd1234));
    rst_ni = 1'b0; dbg_rst_n = 1'b0; dbg_sck = 1'b1; dbg_strobe = 1'b0;
    dbg_sdi = 1'b0; slot = 3'd5;
    wait_n(5);
    // R10 reset state
    check(dbg_sdo === 1'b1 && hyb_sel_n === 5'h1F && arb_num === 3'd0 && cfg === '0,
          "R10 reset", {dbg_sdo, hyb_sel_n, arb_num, 12'(cfg)}, {1'b1, 5'h1F, 3'd0, 12'h0});
    rst_ni = 1'b1; dbg_rst_n = 1'b1;
    wait_n(8);

    // R2 / R7 signature
    addr_shift(sel_addr(slot, 12'h000));
    check(dbg_sdo === 1'b1, "R7 sdo high before first fall", 32'(dbg_sdo), 1);
    shift_bits(16, 32'h0, r);
    check(r[15:0] === 16'h5041, "R2 signature", r, 32'h5041);
    addr_shift(sel_addr(slot, 12'h000));
    shift_bits(16, 32'hFFFF, r);
    check(r[15:0] === 16'h5041, "R2 signature read-only", r, 32'h5041);

    // R3 mode register
    addr_shift(sel_addr(slot, 12'h002));
    shift_bits(4, 32'hB, r);
    check(r[3:0] === 4'h0, "R3 old mode", r, 0);
    check(arb_num === 3'd5, "R3 arb num", 32'(arb_num), 5);
    addr_shift(sel_addr(slot, 12'h002));
    shift_bits(4, 32'h4, r);
    check(r[3:0] === 4'hB && arb_num === 3'd2, "R3 readback", {r[3:0], 1'b0, arb_num}, {4'hB, 4'h2});

    // R4 hybrid selects
    write_mode(4'hB);
    addr_shift(sel_addr(slot, 12'h300));
    check(hyb_sel_n === 5'h1B, "R4 decoded h3", 32'(hyb_sel_n), 32'h1B);
    dbg_strobe = 1'b1;
    wait_n(6);
    check(hyb_sel_n === 5'h1F, "R4 strobe high idle", 32'(hyb_sel_n), 32'h1F);
    dbg_strobe = 1'b0;
    wait_n(2);
    write_mode(4'hA);
    addr_shift(sel_addr(slot, 12'h300));
    check(hyb_sel_n === 5'h19, "R4 encoded h3", 32'(hyb_sel_n), 32'h19);
    for (int k = 0; k < 10; k++) begin
      logic [3:0] h;
      bit dec;
      h = 4'($urandom_range(0, 15));
      dec = bit'($urandom_range(0, 1));
      write_mode({3'd5, dec});
      addr_shift(sel_addr(slot, {h, 8'h00}));
      check(hyb_sel_n === exp_hyb(h, dec), "R4 random hybrid", 32'(hyb_sel_n),
            32'(exp_hyb(h, dec)));
    end

    // R5 board version and shadow
    addr_shift(sel_addr(slot, 12'h003));
    shift_bits(2, 32'h0, r);
    check(r[1:0] === 2'd3, "R5 version before shadow load", r, 3);
    addr_shift(sel_addr(slot, 12'h400));
    shift_bits(1, 32'h0, r);
    check(r[0] === 1'b1, "R5 shadow reset value", r, 1);
    addr_shift(sel_addr(slot, 12'h003));
    shift_bits(2, 32'h0, r);
    check(r[1:0] === 2'd2, "R5 version after shadow load", r, 2);

    // R6 configuration chain pass-through
    prev_cfg = '0;
    for (int k = 0; k < 5; k++) begin
      logic [4:0] chk;
      logic [CFG_W-1:0] dat;
      chk = 5'($urandom);
      dat = CFG_W'($urandom);
      addr_shift(sel_addr(slot, 12'h004));
      shift_bits(CFG_W + 5, 32'({chk, dat}), r);
      exp_v = 32'({prev_cfg, chk});
      check(r[CFG_W+4:0] === exp_v[CFG_W+4:0], "R6 chain stream", r, exp_v);
      check(cfg === dat, "R6 cfg contents", 32'(cfg), 32'(dat));
      prev_cfg = dat;
    end

    // R1 / R8 unselected accesses
    addr_shift(sel_addr(3'd2, 12'h004));
    shift_bits(CFG_W, 32'h0A5, r);
    check(r[CFG_W-1:0] === '1 && cfg === prev_cfg, "R8 wrong slot",
          {r[15:0], 4'h0, 12'(cfg)}, {16'hFFF, 4'h0, 12'(prev_cfg)});
    addr_shift(sel_addr(slot, 12'h002) & 16'h7FFF);
    shift_bits(4, 32'h3, r);
    check(r[3:0] === 4'hF && arb_num === 3'd5, "R1 bit15 clear", {r[3:0], 1'b0, arb_num},
          {4'hF, 4'h5});
    addr_shift(sel_addr(slot, 12'h005));
    shift_bits(CFG_W, 32'h0, r);
    check(r[CFG_W-1:0] === '1 && cfg === prev_cfg, "R8 unmapped offset",
          {r[15:0], 4'h0, 12'(cfg)}, {16'hFFF, 4'h0, 12'(prev_cfg)});
    slot = 3'd3;
    addr_shift(sel_addr(3'd3, 12'h000));
    shift_bits(16, 32'h0, r);
    check(r[15:0] === 16'h5041, "R1 new slot match", r, 32'h5041);

    // R9 bus reset
    dbg_rst_n = 1'b0;
    wait_n(8);
    check(cfg === '0 && arb_num === 3'd0 && hyb_sel_n === 5'h1F && dbg_sdo === 1'b1,
          "R9 bus reset", {dbg_sdo, hyb_sel_n, arb_num, 12'(cfg)}, {1'b1, 5'h1F, 3'd0, 12'h0});
    dbg_rst_n = 1'b1;
    wait_n(6);
    addr_shift(sel_addr(slot, 12'h003));
    shift_bits(2, 32'h0, r);
    check(r[1:0] === 2'd3, "R9 shadow back to 1", r, 3);

    // R10 asynchronous reset
    addr_shift(sel_addr(slot, 12'h004));
    shift_bits(CFG_W, 32'hFFF, r);
    #3 rst_ni = 1'b0;
    #2;
    check(cfg === '0 && arb_num === 3'd0 && dbg_sdo === 1'b1, "R10 async reset",
          {dbg_sdo, 3'd0, arb_num, 12'(cfg)}, {1'b1, 3'd0, 3'd0, 12'h0});
    wait_n(3);
    rst_ni = 1'b1;
    wait_n(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule